// File: doc/BRIEF.md
# PWM / Synchronous-Rectifier Skew Controller

This block sits between a double-ended PWM generator and the gate drivers of a converter with synchronous rectification. It takes the two alternating phase pulses, A and B, and drives four registered gate controls: the two PWM switch drives and the two rectifier drives. Each rectifier drive is the inverse of the *opposite* phase. The A-side rectifier follows the inverse of phase B, and the B-side rectifier follows the inverse of phase A. As a result, both rectifiers conduct while neither switch is on. When one switch is on, only the rectifier that pairs with it conducts.

An unsigned 8-bit skew code, centred on 128, selects which group of outputs is held back and by how many clock cycles. This trims out a mismatch between the switch path and the rectifier path, for example when one path crosses an isolation barrier.

- Codes from 124 to 132 give no skew.
- Lower codes delay the PWM pair.
- Higher codes delay the rectifier pair.

The magnitude grows by one cycle per code step beyond the dead window and saturates at 30 cycles. If both raw phase inputs are high at the same time, the block treats this as a fault and suppresses both PWM drives, so the switches never overlap.

Top module: `sr_skew_ctrl`

## Requirements
- R1: With no skew, sr_a_o equals the inverse of pwm_b_o and sr_b_o equals the inverse of pwm_a_o, and every output follows its input one clock edge after the input is sampled.
- R2: When both phase inputs are low, both PWM outputs settle low and both rectifier outputs settle high (free-wheeling).
- R3: With only phase A high, the outputs settle to pwm_a_o=1, pwm_b_o=0, sr_a_o=1, sr_b_o=0. With only phase B high, they settle to the mirror image, pwm_a_o=0, pwm_b_o=1, sr_a_o=0, sr_b_o=1. The two rectifier outputs are never low together.
- R4: Skew codes 124 through 132 inclusive give zero added delay on all four outputs.
- R5: A code below 124 delays both PWM outputs by (124 − code) cycles and leaves the rectifier outputs undelayed. The response to an input edge then appears (124 − code) + 1 edges after it is sampled.
- R6: A code above 132 delays both rectifier outputs by (code − 132) cycles and leaves the PWM outputs undelayed.
- R7: The added delay saturates at 30 cycles. Code 0 and code 255 each give exactly 30.
- R8: A new skew code is registered first. The output update on the edge that samples the new code still uses the old delay, and the next update uses the new delay.
- R9: During reset the PWM outputs are low and the rectifier outputs are high. The delay lines are preloaded with that state, so after reset a delayed group shows the idle state until its first post-reset input emerges.
- R10: When both phase inputs are high, both PWM outputs are forced low and both rectifier outputs go high, after the group's normal latency.
- R11: pwm_a_o and pwm_b_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_a_i | input | 1 | Raw phase A pulse |
| pwm_b_i | input | 1 | Raw phase B pulse |
| skew_code_i | input | 8 | Skew code, 128 = centre |
| pwm_a_o | output | 1 | Phase A switch drive |
| pwm_b_o | output | 1 | Phase B switch drive |
| sr_a_o | output | 1 | A-side rectifier drive (inverse of phase B) |
| sr_b_o | output | 1 | B-side rectifier drive (inverse of phase A) |

## Verification
The assertions check the following on every cycle:
- the switch drives never overlap and the rectifier drives are never both off;
- at most one group carries a non-zero tap;
- a code in the dead window yields zero taps, and no tap exceeds the saturation limit;
- a zero tap passes its input straight through one edge later, which keeps the cross-paired complement whenever both taps are zero.

The exact delay for a given code, the saturation at both ends, the one-edge lag of a code change and the idle content of the delay lines after reset are shown only by the bench's edge-counting scenarios.

// File: rtl/sr_skew_pkg.sv
package sr_skew_pkg;
    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_PWM  = 2'd1,
        GRP_SR   = 2'd2
    } skew_grp_e;
endpackage

// File: rtl/sr_skew_decode.sv
module sr_skew_decode
    import sr_skew_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int DEAD    = 4,
    parameter int MAX_DLY = 30,
    localparam int TAP_W  = $clog2(MAX_DLY + 1),
    localparam int MID    = 1 << (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic [TAP_W-1:0]  tap_pwm_o,
    output logic [TAP_W-1:0]  tap_sr_o
);
    typedef struct packed {
        logic [TAP_W-1:0] tap_pwm;
        logic [TAP_W-1:0] tap_sr;
    } dec_t;

    dec_t      dec_d, dec_q;
    skew_grp_e grp;
    int        code_int;
    int        mag;

    always_comb begin
        code_int = int'(code_i);
        mag      = 0;
        grp      = GRP_NONE;
        if (code_int < MID - DEAD) begin
            grp = GRP_PWM;
            mag = (MID - DEAD) - code_int;
        end else if (code_int > MID + DEAD) begin
            grp = GRP_SR;
            mag = code_int - (MID + DEAD);
        end
        if (mag > MAX_DLY) mag = MAX_DLY;
        dec_d.tap_pwm = (grp == GRP_PWM) ? TAP_W'(mag) : '0;
        dec_d.tap_sr  = (grp == GRP_SR)  ? TAP_W'(mag) : '0;
    end

    // Tracks the code continuously, also during reset, so the taps are
    // valid on the first edge after reset is released.
    always_ff @(posedge clk) begin
        dec_q <= dec_d;
    end

    assign tap_pwm_o = dec_q.tap_pwm;
    assign tap_sr_o  = dec_q.tap_sr;

    assert_dead_window_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(code_i) >= MID - DEAD && int'(code_i) <= MID + DEAD)
        |=> (tap_pwm_o == '0 && tap_sr_o == '0));

    assert_tap_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(tap_pwm_o) <= MAX_DLY && int'(tap_sr_o) <= MAX_DLY));
endmodule

// File: rtl/sr_skew_dline.sv
module sr_skew_dline #(
    parameter int              WIDTH   = 2,
    parameter int              DEPTH   = 30,
    parameter logic [WIDTH-1:0] RST_VAL = '0,
    localparam int             TAP_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TAP_W-1:0] tap_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    typedef struct packed {
        logic [DEPTH:1][WIDTH-1:0] stage;
        logic [WIDTH-1:0]          out;
    } dl_t;

    dl_t dl_d, dl_q;

    always_comb begin
        dl_d          = dl_q;
        dl_d.stage[1] = din_i;
        for (int k = 2; k <= DEPTH; k++) begin
            dl_d.stage[k] = dl_q.stage[k-1];
        end
        if (tap_i == '0) begin
            dl_d.out = din_i;
        end else if (int'(tap_i) > DEPTH) begin
            dl_d.out = dl_q.stage[DEPTH];
        end else begin
            dl_d.out = dl_q.stage[tap_i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_q.stage <= {DEPTH{RST_VAL}};
            dl_q.out   <= RST_VAL;
        end else begin
            dl_q <= dl_d;
        end
    end

    assign dout_o = dl_q.out;

    // A zero tap is a straight one-edge register of the input.
    assert_zero_tap_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tap_i) == '0) |-> (dout_o == $past(din_i)));
endmodule

// File: rtl/sr_skew_ctrl.sv
module sr_skew_ctrl #(
    parameter int CODE_W  = 8,
    parameter int DEAD    = 4,
    parameter int MAX_DLY = 30,
    localparam int TAP_W  = $clog2(MAX_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_a_i,
    input  logic              pwm_b_i,
    input  logic [CODE_W-1:0] skew_code_i,
    output logic              pwm_a_o,
    output logic              pwm_b_o,
    output logic              sr_a_o,
    output logic              sr_b_o
);
    typedef struct packed {
        logic [1:0] pwm;   // {A, B}
        logic [1:0] sr;    // {A-side, B-side}
    } grp_t;

    grp_t             grp_d;
    logic [TAP_W-1:0] tap_pwm, tap_sr;
    logic [1:0]       pwm_q, sr_q;
    logic             gate_a, gate_b;

    always_comb begin
        // overlapping phases count as a fault: both switches held off
        gate_a    = pwm_a_i & ~pwm_b_i;
        gate_b    = pwm_b_i & ~pwm_a_i;
        grp_d.pwm = {gate_a, gate_b};
        grp_d.sr  = {~gate_b, ~gate_a};
    end

    sr_skew_decode #(
        .CODE_W (CODE_W),
        .DEAD   (DEAD),
        .MAX_DLY(MAX_DLY)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .code_i   (skew_code_i),
        .tap_pwm_o(tap_pwm),
        .tap_sr_o (tap_sr)
    );

    sr_skew_dline #(
        .WIDTH  (2),
        .DEPTH  (MAX_DLY),
        .RST_VAL(2'b00)
    ) u_dline_pwm (
        .clk   (clk),
        .rst   (rst),
        .tap_i (tap_pwm),
        .din_i (grp_d.pwm),
        .dout_o(pwm_q)
    );

    sr_skew_dline #(
        .WIDTH  (2),
        .DEPTH  (MAX_DLY),
        .RST_VAL(2'b11)
    ) u_dline_sr (
        .clk   (clk),
        .rst   (rst),
        .tap_i (tap_sr),
        .din_i (grp_d.sr),
        .dout_o(sr_q)
    );

    assign pwm_a_o = pwm_q[1];
    assign pwm_b_o = pwm_q[0];
    assign sr_a_o  = sr_q[1];
    assign sr_b_o  = sr_q[0];

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(pwm_a_o && pwm_b_o));

    assert_sr_never_both_off_R3: assert property (@(posedge clk) disable iff (rst)
        (sr_a_o || sr_b_o));

    assert_one_group_R5: assert property (@(posedge clk) disable iff (rst)
        !(tap_pwm != '0 && tap_sr != '0));

    assert_cross_pair_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tap_pwm) == '0 && $past(tap_sr) == '0)
        |-> (sr_a_o == !pwm_b_o && sr_b_o == !pwm_a_o));
endmodule

// File: tb/sr_skew_ctrl_tb.sv
module sr_skew_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_in = 1'b0, b_in = 1'b0;
    logic [7:0] code = 8'd128;
    logic       pa, pb, sa, sb;
    int         checks = 0, errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    sr_skew_ctrl u_dut (
        .clk(clk), .rst(rst), .pwm_a_i(a_in), .pwm_b_i(b_in),
        .skew_code_i(code), .pwm_a_o(pa), .pwm_b_o(pb),
        .sr_a_o(sa), .sr_b_o(sb)
    );

    typedef struct packed {
        logic [7:0] code;
        logic       a;
        logic       b;
        logic [3:0] exp;   // {pwm_a, pwm_b, sr_a, sr_b}
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd128, 1'b0, 1'b0, 4'b0011},   // R2 idle
        '{8'd128, 1'b1, 1'b0, 4'b1010},   // R3 phase A
        '{8'd128, 1'b0, 1'b1, 4'b0101},   // R3 phase B
        '{8'd128, 1'b1, 1'b1, 4'b0011},   // R10 fault
        '{8'd0,   1'b1, 1'b0, 4'b1010},   // R3 with PWM delay
        '{8'd255, 1'b0, 1'b1, 4'b0101},   // R3 with SR delay
        '{8'd60,  1'b1, 1'b1, 4'b0011},   // R10 fault, delayed
        '{8'd200, 1'b0, 1'b0, 4'b0011}    // R2 idle, delayed
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Edges from an A rise until pwm_a_o rises and sr_b_o falls
    task automatic measure(input logic [7:0] c, input int dp, input int ds,
                           input string req);
        int kp = 0, ks = 0;
        a_in = 1'b0; b_in = 1'b0; code = c;
        repeat (40) @(negedge clk);
        a_in = 1'b1;
        for (int k = 1; k <= 45; k++) begin
            @(negedge clk);
            if (pa && kp == 0) kp = k;
            if (!sb && ks == 0) ks = k;
        end
        check({req, " pwm latency"}, kp, dp + 1);
        check({req, " sr latency"}, ks, ds + 1);
        a_in = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset with a long PWM delay pending and phase A asserted
        code = 8'd0; a_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 reset outputs", {pa, pb, sa, sb}, 4'b0011);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        check("R9 idle fill", pa, 0);
        @(negedge clk);
        check("R9 first data out", pa, 1);
        a_in = 1'b0;
        repeat (40) @(negedge clk);

        // steady-state table
        for (int i = 0; i < NV; i++) begin
            code = VECS[i].code; a_in = VECS[i].a; b_in = VECS[i].b;
            repeat (40) @(negedge clk);
            check($sformatf("R2/R3/R10 vector %0d", i), {pa, pb, sa, sb},
                  VECS[i].exp);
        end
        a_in = 1'b0; b_in = 1'b0;

        // R1: zero skew, one-edge latency, fault on A and B at once
        code = 8'd128;
        repeat (40) @(negedge clk);
        a_in = 1'b1; b_in = 1'b1;
        @(negedge clk);
        check("R10 fault latency", {pa, pb, sa, sb}, 4'b0011);
        b_in = 1'b0;
        @(negedge clk);
        check("R1 one-edge follow", {pa, pb, sa, sb}, 4'b1010);
        a_in = 1'b0;

        // delay per code
        measure(8'd128, 0, 0, "R4 code 128");
        measure(8'd124, 0, 0, "R4 code 124");
        measure(8'd132, 0, 0, "R4 code 132");
        measure(8'd123, 1, 0, "R5 code 123");
        measure(8'd100, 24, 0, "R5 code 100");
        measure(8'd133, 0, 1, "R6 code 133");
        measure(8'd160, 0, 28, "R6 code 160");
        measure(8'd0, 30, 0, "R7 code 0");
        measure(8'd255, 0, 30, "R7 code 255");

        // R8: code change lags by one edge
        code = 8'd128; a_in = 1'b0;
        repeat (40) @(negedge clk);
        a_in = 1'b1; code = 8'd100;
        @(negedge clk);
        check("R8 old delay on first edge", pa, 1);
        @(negedge clk);
        check("R8 new delay on second edge", pa, 0);
        a_in = 1'b0;
        repeat (40) @(negedge clk);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule